// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds or subtracts two binary32 operands and returns a binary32 result one clock later, together with an overflow flag and an underflow flag. A word holds the sign in bit 31, an 8-bit exponent with a bias of 127 in bits 30 to 23, and a 23-bit fraction in bits 22 to 0. A normal value carries an implied leading 1. The subtract control inverts the sign of the second operand before anything else happens. The datapath has these steps:

- The larger-magnitude operand is chosen first.
- The smaller operand is shifted right by the exponent gap. Three bits are kept below the fraction: guard, round and a sticky OR of everything shifted further.
- The significands are added or subtracted.
- The sum is normalised in either direction.
- The result is rounded to nearest, ties to even, and normalised again if rounding carried out.

Exponent codes 0 and 255 mark zeros, denormals, infinities and NaNs. These are handled by a final selection stage. Denormal operands are accepted as inputs. A nonzero result too small for a normal encoding is flushed to a signed zero and raises underflow. The widths and the output register are parameters. The defaults give the binary32 format with one register stage.

Top module: `fpa_add_sp`

## Requirements
- R1: With both operands normal and no special case, `sum_o` equals the exact sum rounded to nearest. A NaN is any word with exponent 255 and a nonzero fraction.
- R2: When `sub_en` is 1, the result is `opnd_a` minus `opnd_b`. This is the same as adding `opnd_b` with bit 31 inverted.
- R3: The smaller operand is aligned by the exponent difference. Bits shifted below the round position still decide rounding through a sticky bit. An operand 27 or more binades below the other only changes the result through that sticky bit.
- R4: A NaN on either input gives the quiet NaN 0x7FC00000. Infinity minus infinity also gives 0x7FC00000. Both flags stay 0 in these cases.
- R5: An infinite operand combined with a finite operand, or with an infinity of the same effective sign, gives that infinity. Both flags stay 0.
- R6: An exact zero result is +0 (0x00000000), except that the sum of two negative zeros is −0 (0x80000000). No flag is raised.
- R7: If the exponent after rounding is 255 or more, the result is infinity (exponent 255, fraction 0) with the sign of the result, and `ovf_o` is 1.
- R8: If a nonzero result has an exponent below 1 after rounding, the result is a zero with the sign of the result, and `unf_o` is 1.
- R9: An operand with exponent 0 is read with an effective exponent of 1 and no implied bit. Two denormals that sum to 2^-126 give 0x00800000.
- R10: If rounding carries into a new integer bit, the exponent rises by one and the fraction becomes 0.
- R11: While `rst_n` is low, `sum_o`, `ovf_o` and `unf_o` are 0; the reset is asynchronous. Inputs present at a rising clock edge appear on the outputs just after that edge, and the outputs hold until the next edge.
- R12: An exact tie between two representable values rounds to the one whose fraction LSB (bit 0) is 0.
- R13: When subtraction cancels the leading bits, the result is shifted left and the exponent lowered by the number of leading zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_a | input | 32 | First operand (minuend when subtracting) |
| opnd_b | input | 32 | Second operand |
| sub_en | input | 1 | 1 selects a − b, 0 selects a + b |
| sum_o | output | 32 | Rounded result, registered |
| ovf_o | output | 1 | Result exponent overflowed to infinity |
| unf_o | output | 1 | Nonzero result flushed to zero |

## Verification
Most faults in this datapath appear at the ports on the very next cycle as a 1-ulp error. Faults of this kind include a dropped sticky bit, a wrong guard position, or a missing second normalisation after rounding. They show only for operands whose bits straddle the rounding point, so the vectors place set bits exactly at, just above and just below half an ulp. A wrong swap or a wrong leading-zero count gives a result off by whole binades, which cancellation and small-gap vectors expose at once. Faults in the special-case decode appear as a wrong NaN, infinity or zero encoding, or as a wrong flag.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

   // Operand class decoded from the exponent and fraction fields
   typedef enum logic [2:0] {
      FC_ZERO = 3'd0,
      FC_SUB  = 3'd1,
      FC_NORM = 3'd2,
      FC_INF  = 3'd3,
      FC_NAN  = 3'd4
   } fpa_class_e;

   // Extra low-order bits carried through alignment: guard, round, sticky
   localparam int GRS_W = 3;

endpackage

// File: rtl/fpa_unpack.sv
module fpa_unpack #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0]   word_i,
   input  logic                    flip_i,
   output logic                    sign_o,
   output logic [EXP_W-1:0]        exp_o,
   output logic [FRAC_W:0]         sig_o,
   output logic [EXP_W+FRAC_W-1:0] mag_o,
   output fpa_pkg::fpa_class_e     cls_o
);
   logic [EXP_W-1:0]  fld_e;
   logic [FRAC_W-1:0] fld_f;
   logic              e_zero, e_ones, f_zero;

   assign fld_e  = word_i[FRAC_W +: EXP_W];
   assign fld_f  = word_i[FRAC_W-1:0];
   assign e_zero = (fld_e == '0);
   assign e_ones = &fld_e;
   assign f_zero = (fld_f == '0);

   // Effective sign after the optional subtract inversion
   assign sign_o = word_i[EXP_W+FRAC_W] ^ flip_i;
   // Denormals use exponent 1 with no implied bit
   assign exp_o  = e_zero ? {{(EXP_W-1){1'b0}}, 1'b1} : fld_e;
   assign sig_o  = {~e_zero, fld_f};
   assign mag_o  = word_i[EXP_W+FRAC_W-1:0];

   always_comb begin
      if (e_ones)
         cls_o = f_zero ? fpa_pkg::FC_INF : fpa_pkg::FC_NAN;
      else if (e_zero)
         cls_o = f_zero ? fpa_pkg::FC_ZERO : fpa_pkg::FC_SUB;
      else
         cls_o = fpa_pkg::FC_NORM;
   end
endmodule

// File: rtl/fpa_align.sv
module fpa_align #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic                          sign_a_i,
   input  logic [EXP_W-1:0]              exp_a_i,
   input  logic [FRAC_W:0]               sig_a_i,
   input  logic [EXP_W+FRAC_W-1:0]       mag_a_i,
   input  logic                          sign_b_i,
   input  logic [EXP_W-1:0]              exp_b_i,
   input  logic [FRAC_W:0]               sig_b_i,
   input  logic [EXP_W+FRAC_W-1:0]       mag_b_i,
   output logic                          big_sign_o,
   output logic [EXP_W-1:0]              big_exp_o,
   output logic [FRAC_W+fpa_pkg::GRS_W:0] big_ext_o,
   output logic [FRAC_W+fpa_pkg::GRS_W:0] small_ext_o,
   output logic                          eff_sub_o
);
   localparam int SIG_W = FRAC_W + 1;
   localparam int EXT_W = SIG_W + fpa_pkg::GRS_W;

   logic             swap;
   logic [EXP_W-1:0] small_exp, gap;
   logic [SIG_W-1:0] big_sig, small_sig;
   logic [EXT_W-1:0] small_pre, shifted, lost;
   logic             sticky;

   // Compare the raw magnitude fields: the larger one goes on the left
   assign swap       = (mag_b_i > mag_a_i);
   assign big_sign_o = swap ? sign_b_i : sign_a_i;
   assign big_exp_o  = swap ? exp_b_i  : exp_a_i;
   assign small_exp  = swap ? exp_a_i  : exp_b_i;
   assign big_sig    = swap ? sig_b_i  : sig_a_i;
   assign small_sig  = swap ? sig_a_i  : sig_b_i;
   assign eff_sub_o  = sign_a_i ^ sign_b_i;

   assign gap       = big_exp_o - small_exp;
   assign small_pre = {small_sig, {fpa_pkg::GRS_W{1'b0}}};
   assign big_ext_o = {big_sig, {fpa_pkg::GRS_W{1'b0}}};

   always_comb begin
      if (int'(gap) >= EXT_W) begin
         shifted = '0;
         lost    = '0;
         sticky  = |small_sig;
      end else begin
         shifted = small_pre >> gap;
         lost    = small_pre & ~({EXT_W{1'b1}} << gap);
         sticky  = |lost;
      end
   end

   assign small_ext_o = {shifted[EXT_W-1:1], shifted[0] | sticky};
endmodule

// File: rtl/fpa_addnorm.sv
module fpa_addnorm #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [FRAC_W+fpa_pkg::GRS_W:0] big_ext_i,
   input  logic [FRAC_W+fpa_pkg::GRS_W:0] small_ext_i,
   input  logic [EXP_W-1:0]               big_exp_i,
   input  logic                           eff_sub_i,
   output logic [FRAC_W+fpa_pkg::GRS_W:0] norm_o,
   output logic signed [EXP_W+1:0]        exp_o,
   output logic                           zero_o
);
   localparam int EXT_W = FRAC_W + 1 + fpa_pkg::GRS_W;
   localparam int LZ_W  = $clog2(EXT_W + 1);
   localparam int EW    = EXP_W + 2;

   logic [EXT_W:0]          sum;
   logic [LZ_W-1:0]         lz;
   logic signed [EW-1:0]    e_base;

   // Left operand is never smaller, so the difference is non-negative
   assign sum    = eff_sub_i ? ({1'b0, big_ext_i} - {1'b0, small_ext_i})
                             : ({1'b0, big_ext_i} + {1'b0, small_ext_i});
   assign zero_o = (sum == '0);
   assign e_base = {2'b00, big_exp_i};

   // Leading-zero count of the lower EXT_W bits; highest set bit wins
   always_comb begin
      lz = LZ_W'(EXT_W);
      for (int i = 0; i < EXT_W; i++) begin
         if (sum[i]) lz = LZ_W'(EXT_W - 1 - i);
      end
   end

   always_comb begin
      if (sum[EXT_W]) begin
         norm_o = {sum[EXT_W:2], sum[1] | sum[0]};
         exp_o  = e_base + EW'(1);
      end else begin
         norm_o = sum[EXT_W-1:0] << lz;
         exp_o  = e_base - EW'(lz);
      end
   end
endmodule

// File: rtl/fpa_round.sv
module fpa_round #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic                           sign_i,
   input  logic [FRAC_W+fpa_pkg::GRS_W:0] norm_i,
   input  logic signed [EXP_W+1:0]        exp_i,
   output logic [EXP_W+FRAC_W:0]          word_o,
   output logic                           ovf_o,
   output logic                           unf_o
);
   localparam int SIG_W = FRAC_W + 1;
   localparam int EXT_W = SIG_W + fpa_pkg::GRS_W;
   localparam int EW    = EXP_W + 2;
   localparam logic signed [EW-1:0] EMAX_S = EW'((1 << EXP_W) - 1);
   localparam logic signed [EW-1:0] ONE_S  = EW'(1);

   logic                 lsb, grd, rnd, stk, rnd_up;
   logic [SIG_W:0]       rsig;
   logic [FRAC_W-1:0]    frac;
   logic signed [EW-1:0] e_fin;

   assign lsb    = norm_i[3];
   assign grd    = norm_i[2];
   assign rnd    = norm_i[1];
   assign stk    = norm_i[0];
   assign rnd_up = grd & (rnd | stk | lsb);
   assign rsig   = {1'b0, norm_i[EXT_W-1:3]} + (SIG_W+1)'(rnd_up);

   // Second normalisation when rounding carries past the integer bit
   always_comb begin
      if (rsig[SIG_W]) begin
         frac  = rsig[FRAC_W:1];
         e_fin = exp_i + EW'(1);
      end else begin
         frac  = rsig[FRAC_W-1:0];
         e_fin = exp_i;
      end
   end

   always_comb begin
      ovf_o  = 1'b0;
      unf_o  = 1'b0;
      if (e_fin >= EMAX_S) begin
         ovf_o  = 1'b1;
         word_o = {sign_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else if (e_fin < ONE_S) begin
         unf_o  = 1'b1;
         word_o = {sign_i, {(EXP_W+FRAC_W){1'b0}}};
      end else begin
         word_o = {sign_i, e_fin[EXP_W-1:0], frac};
      end
   end
endmodule

// File: rtl/fpa_add_sp.sv
module fpa_add_sp #(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter int REG_OUT = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [EXP_W+FRAC_W:0]   opnd_a,
   input  logic [EXP_W+FRAC_W:0]   opnd_b,
   input  logic                    sub_en,
   output logic [EXP_W+FRAC_W:0]   sum_o,
   output logic                    ovf_o,
   output logic                    unf_o
);
   import fpa_pkg::*;

   localparam int W     = 1 + EXP_W + FRAC_W;
   localparam int SIG_W = FRAC_W + 1;
   localparam int EXT_W = SIG_W + GRS_W;
   localparam int EW    = EXP_W + 2;

   // Elaboration-time parameter checks
   if (EXP_W < 3)                   begin : g_bad_exp  $error("EXP_W must be at least 3"); end
   if (FRAC_W < 2)                  begin : g_bad_frac $error("FRAC_W must be at least 2"); end
   if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg  $error("REG_OUT must be 0 or 1"); end

   logic [W-1:0]           words [2];
   logic                   sgn   [2];
   logic [EXP_W-1:0]       ex    [2];
   logic [SIG_W-1:0]       sg    [2];
   logic [W-2:0]           mg    [2];
   fpa_class_e             cl    [2];

   assign words[0] = opnd_a;
   assign words[1] = opnd_b;

   for (genvar gi = 0; gi < 2; gi++) begin : g_unpack
      fpa_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unpack (
         .word_i (words[gi]),
         .flip_i ((gi == 1) ? sub_en : 1'b0),
         .sign_o (sgn[gi]),
         .exp_o  (ex[gi]),
         .sig_o  (sg[gi]),
         .mag_o  (mg[gi]),
         .cls_o  (cl[gi])
      );
   end

   logic                 big_sign, eff_sub, mag_zero;
   logic [EXP_W-1:0]     big_exp;
   logic [EXT_W-1:0]     big_ext, small_ext, norm;
   logic signed [EW-1:0] norm_exp;
   logic [W-1:0]         rnd_word;
   logic                 rnd_ovf, rnd_unf;

   fpa_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
      .sign_a_i    (sgn[0]),
      .exp_a_i     (ex[0]),
      .sig_a_i     (sg[0]),
      .mag_a_i     (mg[0]),
      .sign_b_i    (sgn[1]),
      .exp_b_i     (ex[1]),
      .sig_b_i     (sg[1]),
      .mag_b_i     (mg[1]),
      .big_sign_o  (big_sign),
      .big_exp_o   (big_exp),
      .big_ext_o   (big_ext),
      .small_ext_o (small_ext),
      .eff_sub_o   (eff_sub)
   );

   fpa_addnorm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_addnorm (
      .big_ext_i   (big_ext),
      .small_ext_i (small_ext),
      .big_exp_i   (big_exp),
      .eff_sub_i   (eff_sub),
      .norm_o      (norm),
      .exp_o       (norm_exp),
      .zero_o      (mag_zero)
   );

   fpa_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
      .sign_i (big_sign),
      .norm_i (norm),
      .exp_i  (norm_exp),
      .word_o (rnd_word),
      .ovf_o  (rnd_ovf),
      .unf_o  (rnd_unf)
   );

   // Special-value selection
   localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   logic [W-1:0] nxt_word;
   logic         nxt_ovf, nxt_unf;
   logic         any_nan, inf_clash;

   assign any_nan   = (cl[0] == FC_NAN) || (cl[1] == FC_NAN);
   assign inf_clash = (cl[0] == FC_INF) && (cl[1] == FC_INF) && (sgn[0] != sgn[1]);

   always_comb begin
      nxt_ovf = 1'b0;
      nxt_unf = 1'b0;
      if (any_nan || inf_clash) begin
         nxt_word = QNAN;
      end else if (cl[0] == FC_INF) begin
         nxt_word = {sgn[0], {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else if (cl[1] == FC_INF) begin
         nxt_word = {sgn[1], {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else if (mag_zero) begin
         nxt_word = {sgn[0] & sgn[1], {(W-1){1'b0}}};
      end else begin
         nxt_word = rnd_word;
         nxt_ovf  = rnd_ovf;
         nxt_unf  = rnd_unf;
      end
   end

   // Output stage variant
   if (REG_OUT == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sum_o <= '0;
            ovf_o <= 1'b0;
            unf_o <= 1'b0;
         end else begin
            sum_o <= nxt_word;
            ovf_o <= nxt_ovf;
            unf_o <= nxt_unf;
         end
      end
   end else begin : g_comb
      assign sum_o = nxt_word;
      assign ovf_o = nxt_ovf;
      assign unf_o = nxt_unf;
   end
endmodule

// File: rtl/fpa_add_chk.sv
module fpa_add_chk #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int LAT    = 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [EXP_W+FRAC_W:0] a,
   input logic [EXP_W+FRAC_W:0] b,
   input logic                  op,
   input logic [EXP_W+FRAC_W:0] res,
   input logic                  ovf,
   input logic                  unf
);
   localparam int W = 1 + EXP_W + FRAC_W;

   logic [W-1:0] d_a, d_b;
   logic         d_op;

   // Align the inputs with the output latency
   if (LAT == 1) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_a  <= '0;
            d_b  <= '0;
            d_op <= 1'b0;
         end else begin
            d_a  <= a;
            d_b  <= b;
            d_op <= op;
         end
      end
   end else begin : g_nodly
      assign d_a  = a;
      assign d_b  = b;
      assign d_op = op;
   end

   function automatic logic is_nan(input logic [W-1:0] x);
      return (&x[W-2:FRAC_W]) && (x[FRAC_W-1:0] != '0);
   endfunction

   function automatic logic is_inf(input logic [W-1:0] x);
      return (&x[W-2:FRAC_W]) && (x[FRAC_W-1:0] == '0);
   endfunction

   logic any_nan_in, a_inf_b_fin, self_cancel;
   assign any_nan_in  = is_nan(d_a) || is_nan(d_b);
   assign a_inf_b_fin = is_inf(d_a) && !(&d_b[W-2:FRAC_W]);
   assign self_cancel = !(&d_a[W-2:FRAC_W]) &&
                        (d_op ? (d_b == d_a) : (d_b == {~d_a[W-1], d_a[W-2:0]}));

   AST_NAN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      any_nan_in |-> (is_nan(res) && !ovf && !unf)); // R4

   AST_INF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      a_inf_b_fin |-> (res == d_a && !ovf && !unf)); // R5

   AST_SELF_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      self_cancel |-> (res == '0 && !unf)); // R6

   AST_OVF_IS_INF: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> is_inf(res)); // R7

   AST_UNF_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      unf |-> (res[W-2:0] == '0)); // R8

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({ovf, unf}) <= 1); // R7
endmodule

bind fpa_add_sp fpa_add_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .LAT(REG_OUT)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .a     (opnd_a),
   .b     (opnd_b),
   .op    (sub_en),
   .res   (sum_o),
   .ovf   (ovf_o),
   .unf   (unf_o)
);

// File: tb/tb_fpa_add_sp.sv
`timescale 1ns/1ps
module tb_fpa_add_sp;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] opnd_a = '0, opnd_b = '0;
   logic        sub_en = 1'b0;
   logic [31:0] sum_o;
   logic        ovf_o, unf_o;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   fpa_add_sp dut (
      .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .sub_en(sub_en), .sum_o(sum_o), .ovf_o(ovf_o), .unf_o(unf_o)
   );

   // {req[3:0], a[31:0], b[31:0], op, result[31:0], ovf, unf}
   localparam int NV = 30;
   localparam logic [102:0] VEC [NV] = '{
      {4'd1,  32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 1'b0, 1'b0}, // R1 1+1
      {4'd1,  32'h3FC00000, 32'h40100000, 1'b0, 32'h40700000, 1'b0, 1'b0}, // R1 1.5+2.25
      {4'd1,  32'hBFC00000, 32'hBFC00000, 1'b0, 32'hC0400000, 1'b0, 1'b0}, // R1 negatives
      {4'd2,  32'h40400000, 32'h3F800000, 1'b1, 32'h40000000, 1'b0, 1'b0}, // R2 3-1
      {4'd2,  32'h3F800000, 32'hC0400000, 1'b0, 32'hC0000000, 1'b0, 1'b0}, // R2 1+(-3)
      {4'd2,  32'h3F800000, 32'hBF800000, 1'b1, 32'h40000000, 1'b0, 1'b0}, // R2 1-(-1)
      {4'd3,  32'h3F800000, 32'h33800001, 1'b0, 32'h3F800001, 1'b0, 1'b0}, // R3 sticky above tie
      {4'd3,  32'h3F800000, 32'h00000001, 1'b0, 32'h3F800000, 1'b0, 1'b0}, // R3 far apart
      {4'd4,  32'h7F800001, 32'h3F800000, 1'b0, 32'h7FC00000, 1'b0, 1'b0}, // R4 NaN a
      {4'd4,  32'h3F800000, 32'hFFC12345, 1'b0, 32'h7FC00000, 1'b0, 1'b0}, // R4 NaN b
      {4'd4,  32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, 1'b0, 1'b0}, // R4 inf-inf
      {4'd5,  32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, 1'b0, 1'b0}, // R5 inf+1
      {4'd5,  32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, 1'b0, 1'b0}, // R5 1-inf
      {4'd5,  32'hFF800000, 32'hFF800000, 1'b0, 32'hFF800000, 1'b0, 1'b0}, // R5 -inf+-inf
      {4'd6,  32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 1'b0, 1'b0}, // R6 1-1
      {4'd6,  32'h80000000, 32'h80000000, 1'b0, 32'h80000000, 1'b0, 1'b0}, // R6 -0+-0
      {4'd6,  32'hBF800000, 32'h3F800000, 1'b0, 32'h00000000, 1'b0, 1'b0}, // R6 -1+1
      {4'd7,  32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 1'b1, 1'b0}, // R7 max+max
      {4'd7,  32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF800000, 1'b1, 1'b0}, // R7 -max-max
      {4'd8,  32'h00800000, 32'h00400000, 1'b1, 32'h00000000, 1'b0, 1'b1}, // R8 flush +
      {4'd8,  32'h80800000, 32'h00400000, 1'b0, 32'h80000000, 1'b0, 1'b1}, // R8 flush -
      {4'd9,  32'h00400000, 32'h00400000, 1'b0, 32'h00800000, 1'b0, 1'b0}, // R9 denorm to normal
      {4'd8,  32'h00000003, 32'h00000001, 1'b1, 32'h00000000, 1'b0, 1'b1}, // R8 denorm diff
      {4'd9,  32'h00400000, 32'h3F800000, 1'b0, 32'h3F800000, 1'b0, 1'b0}, // R9 denorm+1
      {4'd10, 32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 1'b0, 1'b0}, // R10 carry to 2.0
      {4'd10, 32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000, 1'b1, 1'b0}, // R10 carry to overflow
      {4'd10, 32'h40000000, 32'h33800000, 1'b1, 32'h40000000, 1'b0, 1'b0}, // R10 sub then carry
      {4'd12, 32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0, 1'b0}, // R12 tie, even stays
      {4'd12, 32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0, 1'b0}, // R12 tie, odd rounds up
      {4'd13, 32'h3F800001, 32'h3F800000, 1'b1, 32'h34000000, 1'b0, 1'b0}  // R13 cancellation
   };

   task automatic check(input string req, input logic [31:0] r, input logic o, input logic u,
                        input logic [31:0] er, input logic eo, input logic eu);
      checks++;
      if (r !== er || o !== eo || u !== eu) begin
         fails++;
         $display("FAIL %s: actual %h ovf=%b unf=%b expected %h ovf=%b unf=%b",
                  req, r, o, u, er, eo, eu);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R11 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      // R11: reset state
      opnd_a = 32'h3F800000; opnd_b = 32'h3F800000;
      repeat (3) @(posedge clk);
      #2 check("R11 reset", sum_o, ovf_o, unf_o, 32'h0, 1'b0, 1'b0);
      rst_n = 1'b1;

      // Vector table
      for (int i = 0; i < NV; i++) begin
         opnd_a = VEC[i][98:67];
         opnd_b = VEC[i][66:35];
         sub_en = VEC[i][34];
         @(posedge clk);
         #2 check($sformatf("R%0d vec %0d", VEC[i][102:99], i), sum_o, ovf_o, unf_o,
                  VEC[i][33:2], VEC[i][1], VEC[i][0]);
      end

      // R11: one-cycle latency, output holds until the next edge
      opnd_a = 32'h40400000; opnd_b = 32'h3F800000; sub_en = 1'b0;
      @(posedge clk);
      #2;
      opnd_a = 32'h3F800000; opnd_b = 32'h3F800000; sub_en = 1'b0;
      #1 check("R11 hold", sum_o, ovf_o, unf_o, 32'h40800000, 1'b0, 1'b0);
      @(posedge clk);
      #2 check("R11 update", sum_o, ovf_o, unf_o, 32'h40000000, 1'b0, 1'b0);

      // R11: asynchronous reset mid-run clears result and flags
      opnd_a = 32'h7F7FFFFF; opnd_b = 32'h7F7FFFFF;
      @(posedge clk);
      #2 check("R7 pre-reset", sum_o, ovf_o, unf_o, 32'h7F800000, 1'b1, 1'b0);
      rst_n = 1'b0;
      #1 check("R11 async reset", sum_o, ovf_o, unf_o, 32'h0, 1'b0, 1'b0);
      @(posedge clk);
      #2 rst_n = 1'b1;
      @(posedge clk);
      #2 check("R7 after reset", sum_o, ovf_o, unf_o, 32'h7F800000, 1'b1, 1'b0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule